// File: doc/BRIEF.md
# SMBus Register Slave with Byte and Block Access

This block is a two-wire serial slave that answers one fixed device address. Through it, an external bus master can read and write a small array of 8-bit control registers. The first byte after the address is a command. Its top bit picks one of two access styles. In single-byte access the register offset travels in the command. In block access the transfer starts at offset zero and walks upward one register per byte. Block writes normally carry a byte count before the data. A strap input lets the master leave the count out. Block reads always return the count first.

The bus lines are sampled on the system clock through a short synchronizer. The slave sees start, stop, rising-SCL and falling-SCL events on the synchronized lines. It pulls SDA low through an open-drain enable. The rest of the chip sees the register contents on a flat output vector. Selected bits of that vector are read-only: they show hardware status inputs, and bus writes do not touch them.

Top module: `smb_regslave`

## Requirements
- R1: After reset `sda_pull` is 0. `regs_out` holds the reset values, and each read-only bit holds the matching `hw_status` bit.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged: the slave holds SDA low in the ninth clock. Any other address is not acknowledged, and the rest of that transaction is ignored. The slave only starts pulling SDA low while SCL is low.
- R3: A command byte with bit 7 = 1 selects single-byte access, with bits 6:0 as the offset. The data byte that follows is written to that register and acknowledged.
- R4: A single-byte read is command, repeated start, 0xD3, then the slave sends the register at the commanded offset, most significant bit first.
- R5: Command 0x00 selects block access. With `no_count` = 0, the byte after the command is a count that is acknowledged and not stored. The data bytes that follow go to offsets 0, 1, 2 and upward.
- R6: With `no_count` = 1, a block write treats the first byte after the command as data for offset 0.
- R7: A block read returns the number of registers (NUM_REGS, 8 by default) first. It then returns offset 0 and upward, for as long as the master acknowledges.
- R8: The master may issue a stop after any complete byte. Only the data bytes already received are written, and later registers keep their values.
- R9: A bit set in RO_MASK (by default bits 2:0 of offset 6) always shows `hw_status`, and writes leave it unchanged.
- R10: A write to an offset at or above NUM_REGS is acknowledged and discarded. A read from such an offset returns 0x00.
- R11: After the master answers a read byte with no-acknowledge, the slave releases SDA until the next start or stop. It never pulls SDA while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| no_count | input | 1 | 1 = block writes carry no byte count |
| hw_status | input | NUM_REGS*8 | Hardware values shown in read-only bits |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| regs_out | output | NUM_REGS*8 | Register contents, offset 0 in the low byte |

## Verification
A wrong bit counter or phase shows up within one byte time, as an acknowledge in the wrong slot or a missing acknowledge. It can also show up as a read byte that is shifted by one bit. A wrong pointer shows up only when data lands at a neighbouring offset. The bench therefore compares the whole register vector against a reference model on every clock between transactions. Read-only bits and discarded out-of-range writes are checked by reading back through the bus after the write.

// File: rtl/smb_regslave_pkg.sv
package smb_regslave_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_WDATA,
        PH_RDATA,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic [BYTE_W-1:0] merge_ro(
        input logic [BYTE_W-1:0] stored,
        input logic [BYTE_W-1:0] hw,
        input logic [BYTE_W-1:0] mask
    );
        return (stored & ~mask) | (hw & mask);
    endfunction

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync
    import smb_regslave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now  = scl_pipe[STAGES-1];
    assign sda_now  = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl   = scl_now;
        ev.sda   = sda_now;
        ev.rise  = scl_now & ~scl_d;
        ev.fall  = ~scl_now & scl_d;
        ev.start = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop  = scl_now & scl_d & ~sda_d & sda_now;
    end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_regslave_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] RST_VALS = '0,
    parameter logic [NUM_REGS*8-1:0] RO_MASK  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            wr_ptr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_ptr,
    input  logic [NUM_REGS*8-1:0] hw_status,
    output logic [NUM_REGS*8-1:0] view,
    output logic [NUM_REGS*8-1:0] store,
    output logic [7:0]            rd_data
);
    localparam logic [7:0] NREG8 = 8'(NUM_REGS);
    localparam int         IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0] view_a [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] MSK = RO_MASK[g*8 +: 8];
        localparam logic [7:0] RV  = RST_VALS[g*8 +: 8];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= RV & ~MSK;
            else if (wr_en && wr_ptr == 8'(g))
                q <= wr_data & ~MSK;
        end

        assign store[g*8 +: 8] = q;
        assign view_a[g]       = merge_ro(q, hw_status[g*8 +: 8], MSK);
        assign view[g*8 +: 8]  = view_a[g];
    end

    assign rd_data = (rd_ptr < NREG8) ? view_a[rd_ptr[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_regslave_pkg::*;
#(
    parameter logic [6:0]            DEV_ADDR    = 7'h69,
    parameter int                    NUM_REGS    = 8,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] RST_VALS    = 64'h1830_0F00_00FF_FEFF,
    parameter logic [NUM_REGS*8-1:0] RO_MASK     = 64'h0007_0000_0000_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic                  no_count,
    input  logic [NUM_REGS*8-1:0] hw_status,
    output logic                  sda_pull,
    output logic [NUM_REGS*8-1:0] regs_out
);
    localparam logic [7:0] NREG8 = 8'(NUM_REGS);

    bus_ev_t               ev;
    logic                  scl_sync;
    phase_e                phase;
    logic [3:0]            bitn;
    logic                  ack_phase;
    logic                  slave_ack;
    logic [7:0]            sr;
    logic [7:0]            ptr;
    logic                  block_mode;
    logic                  send_count;
    logic                  wr_en;
    logic [7:0]            wr_ptr;
    logic [7:0]            wr_data;
    logic [7:0]            rd_data;
    logic [7:0]            tx_byte;
    logic [2:0]            bit_sel;
    logic [NUM_REGS*8-1:0] store;

    smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .RST_VALS (RST_VALS),
        .RO_MASK  (RO_MASK)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .rd_ptr    (ptr),
        .hw_status (hw_status),
        .view      (regs_out),
        .store     (store),
        .rd_data   (rd_data)
    );

    assign scl_sync = ev.scl;
    assign tx_byte  = send_count ? NREG8 : rd_data;
    assign bit_sel  = 3'd7 - bitn[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bitn       <= '0;
            ack_phase  <= 1'b0;
            slave_ack  <= 1'b0;
            sr         <= '0;
            ptr        <= '0;
            block_mode <= 1'b0;
            send_count <= 1'b0;
            sda_pull   <= 1'b0;
            wr_en      <= 1'b0;
            wr_ptr     <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                phase     <= PH_ADDR;
                bitn      <= '0;
                ack_phase <= 1'b0;
                slave_ack <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (ev.stop) begin
                phase     <= PH_IDLE;
                ack_phase <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (phase != PH_IDLE && phase != PH_WAIT) begin
                if (ev.rise) begin
                    if (ack_phase) begin
                        if (!slave_ack && phase == PH_RDATA) begin
                            if (ev.sda)
                                phase <= PH_WAIT;
                            else if (send_count)
                                send_count <= 1'b0;
                            else if (ptr != 8'hFF)
                                ptr <= ptr + 8'd1;
                        end
                    end else if (bitn < 4'd8) begin
                        sr   <= {sr[6:0], ev.sda};
                        bitn <= bitn + 4'd1;
                    end
                end else if (ev.fall) begin
                    if (ack_phase) begin
                        ack_phase <= 1'b0;
                        bitn      <= '0;
                        sda_pull  <= (phase == PH_RDATA) ? ~tx_byte[7] : 1'b0;
                    end else if (bitn == 4'd8) begin
                        ack_phase <= 1'b1;
                        slave_ack <= (phase != PH_RDATA);
                        sda_pull  <= 1'b1;
                        case (phase)
                            PH_ADDR: begin
                                if (sr[7:1] != DEV_ADDR) begin
                                    sda_pull <= 1'b0;
                                    phase    <= PH_WAIT;
                                end else if (sr[0]) begin
                                    phase      <= PH_RDATA;
                                    send_count <= block_mode;
                                end else begin
                                    phase <= PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                block_mode <= ~sr[7];
                                ptr        <= sr[7] ? {1'b0, sr[6:0]} : 8'h00;
                                phase      <= (!sr[7] && !no_count) ? PH_COUNT : PH_WDATA;
                            end
                            PH_COUNT: phase <= PH_WDATA;
                            PH_WDATA: begin
                                wr_en   <= 1'b1;
                                wr_ptr  <= ptr;
                                wr_data <= sr;
                                if (ptr != 8'hFF)
                                    ptr <= ptr + 8'd1;
                            end
                            default: sda_pull <= 1'b0;
                        endcase
                    end else if (phase == PH_RDATA && bitn != 4'd0) begin
                        sda_pull <= ~tx_byte[bit_sel];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk
    import smb_regslave_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] RO_MASK  = '0
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_sync,
    input logic                  sda_pull,
    input phase_e                phase,
    input logic                  wr_en,
    input logic [7:0]            wr_ptr,
    input logic [NUM_REGS*8-1:0] store,
    input logic [NUM_REGS*8-1:0] regs_out,
    input logic [NUM_REGS*8-1:0] hw_status
);
    localparam logic [7:0] NREG8 = 8'(NUM_REGS);

    AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> !sda_pull); // R1

    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_sync); // R2

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(store)); // R3

    AST_RO_FOLLOWS_HW: assert property (@(posedge clk) disable iff (rst)
        $stable(hw_status & RO_MASK) |-> $stable(regs_out & RO_MASK)); // R9

    AST_OOR_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ptr >= NREG8) |=> $stable(store)); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_WAIT) |-> !sda_pull); // R11
endmodule

bind smb_regslave smb_regslave_chk #(
    .NUM_REGS (NUM_REGS),
    .RO_MASK  (RO_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_sync  (scl_sync),
    .sda_pull  (sda_pull),
    .phase     (phase),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .store     (store),
    .regs_out  (regs_out),
    .hw_status (hw_status)
);

// File: tb/test_smb_regslave.sv
module test_smb_regslave;
    localparam int              CLK_PERIOD = 10;
    localparam int              Q          = 8;
    localparam int              NREG       = 8;
    localparam logic [63:0]     RSTV       = 64'h1830_0F00_00FF_FEFF;
    localparam logic [63:0]     ROM        = 64'h0007_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        m_sda = 1'b1;
    logic        no_count = 1'b0;
    logic [63:0] hw = 64'h0005_0000_0000_0000;
    logic        sda_pull;
    logic [63:0] regs_out;
    logic        sda_wire;

    logic [7:0]  model [NREG];
    logic        cmp_en = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    assign sda_wire = m_sda & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_regslave #(
        .DEV_ADDR (7'h69),
        .NUM_REGS (NREG),
        .RST_VALS (RSTV),
        .RO_MASK  (ROM)
    ) i_smb_regslave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_wire),
        .no_count  (no_count),
        .hw_status (hw),
        .sda_pull  (sda_pull),
        .regs_out  (regs_out)
    );

    function automatic logic [63:0] exp_vec();
        logic [63:0] v;
        for (int i = 0; i < NREG; i++)
            v[i*8 +: 8] = (model[i] & ~ROM[i*8 +: 8]) | (hw[i*8 +: 8] & ROM[i*8 +: 8]);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference comparison on every clock between transactions (R3 R5 R6 R8 R10)
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (regs_out !== exp_vec()) begin
                errors++;
                $display("FAIL regmodel_R8 actual=%h expected=%h", regs_out, exp_vec());
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        cmp_en = 1'b0;
        m_sda = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q/2);
        acked = ~sda_wire;
        wq(Q/2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q/2);
            b[i] = sda_wire;
            wq(Q/2);
            scl_m = 1'b0;
        end
        wq(2);
        m_sda = nack; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic finish_txn();
        wq(4);
        cmp_en = 1'b1;
        wq(4);
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d, input string req);
        bit a;
        bus_start();
        wr_byte(8'hD2, a);          chk(a, req, 64'(a), 64'd1);
        wr_byte({1'b1, off}, a);    chk(a, req, 64'(a), 64'd1);
        wr_byte(d, a);              chk(a, req, 64'(a), 64'd1);
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d, input string req);
        bit a;
        bus_start();
        wr_byte(8'hD2, a);          chk(a, req, 64'(a), 64'd1);
        wr_byte({1'b1, off}, a);    chk(a, req, 64'(a), 64'd1);
        bus_start();
        wr_byte(8'hD3, a);          chk(a, req, 64'(a), 64'd1);
        rd_byte(1'b1, d);
        wq(2);
        chk(sda_pull == 1'b0, "R11 release after nack", 64'(sda_pull), 64'd0);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        bit          a;
        logic [7:0]  d;
        for (int i = 0; i < NREG; i++) model[i] = RSTV[i*8 +: 8];
        wq(6);
        rst = 1'b0;
        wq(4);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 sda released", 64'(sda_pull), 64'd0);
        chk(regs_out === exp_vec(), "R1 reset values", regs_out, exp_vec());
        cmp_en = 1'b1;

        // R2 foreign address not acknowledged, rest ignored
        bus_start();
        wr_byte(8'hA0, a);   chk(!a, "R2 foreign address nack", 64'(a), 64'd0);
        wr_byte(8'h83, a);   chk(!a, "R2 ignored after nack", 64'(a), 64'd0);
        wr_byte(8'h00, a);
        bus_stop();
        finish_txn();

        // R3 byte write, R4 byte read
        byte_write(7'd3, 8'h5A, "R2 R3 byte write ack");
        model[3] = 8'h5A;
        finish_txn();
        byte_read(7'd3, d, "R4 byte read ack");
        chk(d == 8'h5A, "R4 byte read data", 64'(d), 64'h5A);
        finish_txn();

        // R5 block write with count
        no_count = 1'b0;
        bus_start();
        wr_byte(8'hD2, a); chk(a, "R5 addr", 64'(a), 64'd1);
        wr_byte(8'h00, a); chk(a, "R5 cmd", 64'(a), 64'd1);
        wr_byte(8'h03, a); chk(a, "R5 count ack", 64'(a), 64'd1);
        wr_byte(8'h11, a);
        wr_byte(8'h22, a);
        wr_byte(8'h33, a); chk(a, "R5 data ack", 64'(a), 64'd1);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        finish_txn();
        chk(regs_out[23:0] == 24'h332211, "R5 block write", 64'(regs_out[23:0]), 64'h332211);

        // R6 block write without count
        no_count = 1'b1;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h44, a);
        wr_byte(8'h55, a); chk(a, "R6 data ack", 64'(a), 64'd1);
        bus_stop();
        model[0] = 8'h44; model[1] = 8'h55;
        finish_txn();
        chk(regs_out[15:0] == 16'h5544, "R6 no count", 64'(regs_out[15:0]), 64'h5544);
        no_count = 1'b0;

        // R8 stop after one data byte
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h05, a);
        wr_byte(8'h99, a);
        bus_stop();
        model[0] = 8'h99;
        finish_txn();
        chk(regs_out[15:0] == 16'h5599, "R8 early stop", 64'(regs_out[15:0]), 64'h5599);

        // R7 block read
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        bus_start();
        wr_byte(8'hD3, a); chk(a, "R7 read addr ack", 64'(a), 64'd1);
        rd_byte(1'b0, d);
        chk(d == 8'(NREG), "R7 count byte", 64'(d), 64'(NREG));
        for (int i = 0; i < NREG; i++) begin
            rd_byte(i == NREG - 1, d);
            chk(d == exp_vec()[i*8 +: 8], "R7 block read data", 64'(d), 64'(exp_vec()[i*8 +: 8]));
        end
        wq(2);
        chk(sda_pull == 1'b0, "R11 release after block nack", 64'(sda_pull), 64'd0);
        bus_stop();
        finish_txn();

        // R9 read-only bits
        byte_write(7'd6, 8'hFF, "R9 write ack");
        model[6] = 8'hFF;
        finish_txn();
        byte_read(7'd6, d, "R9 read ack");
        chk(d == 8'hFD, "R9 ro bits hold status", 64'(d), 64'hFD);
        finish_txn();
        hw = 64'h0002_0000_0000_0000;
        wq(2);
        byte_read(7'd6, d, "R9 read ack");
        chk(d == 8'hFA, "R9 ro bits follow status", 64'(d), 64'hFA);
        finish_txn();

        // R10 out-of-range offset
        byte_write(7'h14, 8'h77, "R10 oor write ack");
        finish_txn();
        byte_read(7'h14, d, "R10 oor read ack");
        chk(d == 8'h00, "R10 oor read zero", 64'(d), 64'h00);
        finish_txn();
        chk(sda_pull == 1'b0, "R11 idle quiet", 64'(sda_pull), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule